// File: doc/BRIEF.md
# Mirror-Extending Bidirectional Routing Network

This block feeds a row-wide array of processing elements, one per column. A whole row of samples, one slice of `W` bits per column, is captured in a single cycle. The block then walks that row through two opposed shift chains. One chain carries samples rightwards, so each column sees its left-hand neighbours. The other carries them leftwards, so each column sees its right-hand neighbours. At each end of the row the two chains are tied into one ring. A sample that falls off one chain re-enters the other, and the processing elements see a symmetrically extended row without any padding ever being stored.

A step request advances both chains by a stride of `2^octave` single-column moves, one move per cycle. At each step the block raises a one-cycle valid strobe, and the processing element in column `j` then holds the samples at distance `k` on both sides, where `k` is the total count of moves since the last load. Each column also keeps its own loaded sample for the whole row operation.

Top module: `mirror_route_net`

## Requirements
- R1: While and after synchronous reset, with no load yet, `out_valid` and `busy` are 0 and all three sample buses are zero.
- R2: A `load` sampled at a clock edge makes `center_out`, `left_out` and `right_out` equal `row_in` after that edge, with `out_valid` high for that one cycle. Column `j` occupies bits `[j*W +: W]` of every row-wide bus.
- R3: After `k` single-column moves since the last load, `left_out` of column `j` equals sample `j-k` and `right_out` of column `j` equals sample `j+k` of the extended row.
- R4: The extended row repeats the edge sample and mirrors outward: index `-1-m` maps to sample `m`, and index `N+m` maps to sample `N-1-m`, where `N` is the column count.
- R5: A step accepted at an edge with `octave` = `o` performs `2^o` moves, one per cycle starting at that edge. `out_valid` goes high at the edge of the last move, and `busy` is high in between.
- R6: A `step` that arrives while `busy` is high is ignored. It produces no valid strobe and moves nothing.
- R7: When `load` and `step` are high in the same cycle, the load takes effect and the step is discarded.
- R8: `center_out` changes only on a load; steps never alter it.
- R9: After `2N` moves the chains hold the loaded row again, so the extension is periodic with period `2N`.
- R10: `out_valid` is a single-cycle pulse unless a new load or stride-1 step is accepted in its cycle, and it is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `row_in` into every column |
| row_in | input | NCOL*W | Row slice, column j at bits [j*W +: W] |
| step | input | 1 | Request one stride of moves |
| octave | input | OCTW | Stride exponent, stride = 2^octave |
| center_out | output | NCOL*W | Loaded sample of each column |
| left_out | output | NCOL*W | Left-neighbour sample of each column |
| right_out | output | NCOL*W | Right-neighbour sample of each column |
| out_valid | output | 1 | One-cycle strobe: load done or stride done |
| busy | output | 1 | A multi-cycle stride is in progress |

## Verification
A row load and a step request can arrive in the same cycle, and so can a step request and an unfinished stride. The bench provokes the first by raising `load` and `step` together. The scoreboard then expects exactly one item, the freshly loaded row at distance zero, and a later single step must show distance one, which proves the discarded step moved nothing. The second case is provoked by holding `step` high into the first busy cycle of a four-move stride. It is judged by the scoreboard seeing one item only, at distance four, and by an empty queue at the end.

// File: rtl/mrn_pkg.sv
package mrn_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_t;
endpackage

// File: rtl/mrn_cell.sv
// One column of the network: loaded sample plus one stage of each chain.
module mrn_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         sh,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] rin,   // from the column on the left (or the ring turn)
  input  logic [W-1:0] lin,   // from the column on the right (or the ring turn)
  output logic [W-1:0] ctr_q,
  output logic [W-1:0] rq,
  output logic [W-1:0] lq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
      rq    <= '0;
      lq    <= '0;
    end else if (ld) begin
      ctr_q <= ld_val;
      rq    <= ld_val;
      lq    <= ld_val;
    end else if (sh) begin
      rq <= rin;
      lq <= lin;
    end
  end
endmodule

// File: rtl/mrn_seq.sv
// Stride sequencer: turns one step request into 2^octave single moves.
module mrn_seq
  import mrn_pkg::*;
#(
  parameter int OCTW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [OCTW-1:0] oct_i,
  output logic            shift_o,
  output logic            valid_o,
  output logic            busy_o
);
  localparam int MAXSH = 1 << ((1 << OCTW) - 1);
  localparam int CNTW  = $clog2(MAXSH + 1);

  sq_state_t       state;
  logic [CNTW-1:0] rem;
  logic [CNTW-1:0] stride;
  logic            accept;

  assign stride  = {{(CNTW-1){1'b0}}, 1'b1} << oct_i;
  assign accept  = !load_i && (state == SQ_IDLE) && step_i;
  assign shift_o = !load_i && (accept || (state == SQ_RUN));
  assign busy_o  = (state == SQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      rem     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (load_i) begin
        state   <= SQ_IDLE;
        rem     <= '0;
        valid_o <= 1'b1;
      end else if (accept) begin
        if (stride == {{(CNTW-1){1'b0}}, 1'b1}) begin
          valid_o <= 1'b1;
        end else begin
          state <= SQ_RUN;
          rem   <= stride - 1'b1;
        end
      end else if (state == SQ_RUN) begin
        rem <= rem - 1'b1;
        if (rem == {{(CNTW-1){1'b0}}, 1'b1}) begin
          valid_o <= 1'b1;
          state   <= SQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/mirror_route_net.sv
module mirror_route_net #(
  parameter int NCOL = 8,
  parameter int W    = 4,
  parameter int OCTW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NCOL*W-1:0]    row_in,
  input  logic                 step,
  input  logic [OCTW-1:0]      octave,
  output logic [NCOL*W-1:0]    center_out,
  output logic [NCOL*W-1:0]    left_out,
  output logic [NCOL*W-1:0]    right_out,
  output logic                 out_valid,
  output logic                 busy
);
  localparam int LAST = NCOL - 1;

  logic         shift_act;
  logic [W-1:0] rch [NCOL];
  logic [W-1:0] lch [NCOL];
  logic [W-1:0] ctr [NCOL];

  mrn_seq #(.OCTW(OCTW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .step_i  (step),
    .oct_i   (octave),
    .shift_o (shift_act),
    .valid_o (out_valid),
    .busy_o  (busy)
  );

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    logic [W-1:0] rin;
    logic [W-1:0] lin;
    if (j == 0) begin : g_lturn
      assign rin = lch[0];          // left edge: leftward chain turns right
    end else begin : g_rlink
      assign rin = rch[j-1];
    end
    if (j == LAST) begin : g_rturn
      assign lin = rch[LAST];       // right edge: rightward chain turns left
    end else begin : g_llink
      assign lin = lch[j+1];
    end

    mrn_cell #(.W(W)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .ld     (load),
      .sh     (shift_act),
      .ld_val (row_in[j*W +: W]),
      .rin    (rin),
      .lin    (lin),
      .ctr_q  (ctr[j]),
      .rq     (rch[j]),
      .lq     (lch[j])
    );

    assign center_out[j*W +: W] = ctr[j];
    assign left_out[j*W +: W]   = rch[j];
    assign right_out[j*W +: W]  = lch[j];
  end
endmodule

// File: rtl/mrn_chk.sv
module mrn_chk #(
  parameter int NCOL = 8,
  parameter int W    = 4,
  parameter int OCTW = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [NCOL*W-1:0] row_in,
  input logic              step,
  input logic [OCTW-1:0]   octave,
  input logic [NCOL*W-1:0] center_out,
  input logic [NCOL*W-1:0] left_out,
  input logic [NCOL*W-1:0] right_out,
  input logic              out_valid,
  input logic              busy,
  input logic              shift_act
);
  localparam int MAXSH = 1 << ((1 << OCTW) - 1);
  localparam int CNTW  = $clog2(MAXSH + 1) + 1;

  logic            armed;
  logic [CNTW-1:0] mv_cnt;
  logic [CNTW-1:0] mv_exp;
  logic            acc;

  assign acc = step && !busy && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      mv_cnt <= '0;
      mv_exp <= '0;
    end else if (load) begin
      armed  <= 1'b0;
      mv_cnt <= '0;
    end else if (acc) begin
      armed  <= 1'b1;
      mv_exp <= {{(CNTW-1){1'b0}}, 1'b1} << octave;
      mv_cnt <= {{(CNTW-1){1'b0}}, 1'b1};
    end else begin
      if (out_valid) armed <= 1'b0;
      if (shift_act) mv_cnt <= mv_cnt + 1'b1;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (out_valid && center_out == $past(row_in) &&
              left_out == $past(row_in) && right_out == $past(row_in)));

  assert_edge_mirror_R4: assert property (@(posedge clk) disable iff (rst)
    shift_act |=> (left_out[W-1:0] == $past(right_out[W-1:0]) &&
                   right_out[NCOL*W-1 -: W] == $past(left_out[NCOL*W-1 -: W])));

  assert_stride_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && armed) |-> (mv_cnt == mv_exp));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && step && !load) |-> shift_act);

  assert_center_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(center_out));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !load && !step) |=> !out_valid);

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, busy}));
endmodule

bind mirror_route_net mrn_chk #(.NCOL(NCOL), .W(W), .OCTW(OCTW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .row_in     (row_in),
  .step       (step),
  .octave     (octave),
  .center_out (center_out),
  .left_out   (left_out),
  .right_out  (right_out),
  .out_valid  (out_valid),
  .busy       (busy),
  .shift_act  (shift_act)
);

// File: tb/mirror_route_net_bench.sv
module mirror_route_net_bench;
  localparam int N    = 8;
  localparam int W    = 4;
  localparam int OCTW = 2;
  localparam int RW   = N * W;

  typedef struct {
    logic [RW-1:0] l;
    logic [RW-1:0] r;
    logic [RW-1:0] c;
    string         tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            load = 1'b0;
  logic [RW-1:0]   row_in = '0;
  logic            step = 1'b0;
  logic [OCTW-1:0] octave = '0;
  logic [RW-1:0]   center_out, left_out, right_out;
  logic            out_valid, busy;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  item_t expq[$];
  logic [W-1:0] xrow [N];
  int    kpos = 0;

  always #2.5 clk = ~clk;

  mirror_route_net #(.NCOL(N), .W(W), .OCTW(OCTW)) u_mirror_route_net (
    .clk(clk), .rst(rst), .load(load), .row_in(row_in), .step(step),
    .octave(octave), .center_out(center_out), .left_out(left_out),
    .right_out(right_out), .out_valid(out_valid), .busy(busy)
  );

  // Symmetric extension with the edge sample repeated (R4), period 2N (R9)
  function automatic logic [W-1:0] ext(int idx);
    int p;
    p = ((idx % (2 * N)) + 2 * N) % (2 * N);
    if (p >= N) p = 2 * N - 1 - p;
    return xrow[p];
  endfunction

  function automatic item_t build(string tag);
    item_t it;
    for (int j = 0; j < N; j++) begin
      it.l[j*W +: W] = ext(j - kpos);
      it.r[j*W +: W] = ext(j + kpos);
      it.c[j*W +: W] = xrow[j];
    end
    it.tag = tag;
    return it;
  endfunction

  task automatic check(string tag, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_load(int seed, string tag, bit with_step);
    for (int j = 0; j < N; j++) begin
      xrow[j] = W'((j * 5 + seed) % 16);
      row_in[j*W +: W] = xrow[j];
    end
    kpos = 0;
    expq.push_back(build(tag));
    @(negedge clk);
    load = 1'b1;
    step = with_step;
    @(negedge clk);
    load = 1'b0;
    step = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_step(int oct, string tag, bit extra);
    int s;
    s = 1 << oct;
    kpos += s;
    expq.push_back(build(tag));
    @(negedge clk);
    octave = OCTW'(oct);
    step = 1'b1;
    @(negedge clk);
    step = extra;
    @(negedge clk);
    step = 1'b0;
    repeat (s + 1) @(negedge clk);
  endtask

  // Monitor: pops expected items as the design strobes results
  initial begin
    bit prev_v;
    prev_v = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_v && out_valid) begin
          n_chk++; n_fail++;
          $display("FAIL R10 valid held two cycles actual=1 expected=0");
        end
        if (out_valid) begin
          if (expq.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R6 unexpected valid actual=1 expected=0");
          end else begin
            item_t e;
            e = expq.pop_front();
            check(e.tag, "left_out", left_out, e.l);
            check(e.tag, "right_out", right_out, e.r);
            check({e.tag, "/R8"}, "center_out", center_out, e.c);
          end
        end
        prev_v = out_valid;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "left_out", left_out, '0);
    check("R1", "right_out", right_out, '0);
    check("R1", "center_out", center_out, '0);
    check("R1", "valid/busy", RW'({out_valid, busy}), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid/busy after release", RW'({out_valid, busy}), '0);

    do_load(3, "R2", 1'b0);
    for (int i = 0; i < 3; i++) do_step(0, "R3", 1'b0);     // k = 1..3
    for (int i = 0; i < 6; i++) do_step(0, "R4", 1'b0);     // k = 4..9, past both edges
    do_step(1, "R5", 1'b0);                                // k = 11
    do_step(2, "R5", 1'b0);                                // k = 15
    do_step(0, "R9", 1'b0);                                // k = 16: loaded row again
    do_step(3, "R5", 1'b0);                                // k = 24

    do_load(7, "R2", 1'b0);
    do_step(2, "R6", 1'b1);                                // extra step while busy ignored

    do_load(11, "R7", 1'b1);                               // load wins over step
    do_step(0, "R7", 1'b0);                                // distance must be 1

    repeat (4) @(negedge clk);
    check("R6", "leftover expected items", RW'(expq.size()), '0);
    check("R10", "valid/busy idle", RW'({out_valid, busy}), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule